// File: doc/BRIEF.md
# Instruction Decoder with Zero-Compare Branch Evaluation

This block turns one 32-bit instruction word into the control fields that an execute stage needs. The word holds a 6-bit major opcode in bits 31:26, a second register field in bits 20:16 and, for register-register operations, a 6-bit function code in bits 5:0. The block produces four things:

- an ALU function select;
- a flag that marks unsigned arithmetic;
- a flag that says the result is taken from the sign of a subtraction (set-on-less-than);
- a branch kind, together with whether the branch is taken.

Any word that falls into an unassigned encoding slot raises a reserved flag. The rest of the pipeline is expected to trap on that flag. All other outputs are then forced to zero.

The two compare-with-zero branches evaluate their condition here. They feed the first source value, `rs_value`, into an equality comparator whose other input is tied to zero, and then combine the result with the sign bit of `rs_value`. Related operations sit in aligned groups of the code space, so one decode term covers a whole group. The two set-on-less-than codes differ from the matching subtract codes in bit 3 only, and decode to the same subtract function.

All outputs are registered and appear one clock after the word is presented.

Top module: `rdec_top`

## Requirements
- R1: The all-zero word decodes as a left shift (alu_sel 0) with no flags, branch kind 0, not taken and not reserved, so it acts as a no-operation.
- R2: With major opcode 0, these function codes select these alu_sel values: 0 gives 0 (shift left), 2 gives 1 (shift right logical), 3 gives 2 (shift right arithmetic), 32 gives 3 (add), 34 gives 4 (subtract), 36 gives 5 (and), 37 gives 6 (or), 38 gives 7 (xor), 39 gives 8 (nor).
- R3: Function codes 42 and 43 select alu_sel 4 (subtract) and raise sign_result. In this encoding each differs from subtract (34) or subtract-unsigned (35) in bit 3 only.
- R4: is_unsigned is 1 for function codes 33 (add, alu 3), 35 (subtract, alu 4) and 43, and for major opcodes 9 and 11. It is 0 for every other word.
- R5: The immediate major opcodes decode as follows: 8 gives add, 9 gives add unsigned, 10 gives subtract with sign_result, 11 gives subtract with sign_result and unsigned, 12 gives and, 13 gives or, 14 gives xor.
- R6: Major opcode 6 gives branch_kind 01 (less-or-equal zero) and major opcode 7 gives branch_kind 10 (greater than zero), both with alu_sel 0. Every other word gives branch_kind 00.
- R7: A less-or-equal-zero branch is taken when rs_value equals zero or bit 31 of rs_value is 1.
- R8: A greater-than-zero branch is taken when rs_value is nonzero and bit 31 is 0.
- R9: A major opcode 6 or 7 whose bits 20:16 are nonzero is reserved: branch_kind 00 and not taken.
- R10: Every major opcode not listed above, and every function code under major opcode 0 not listed above, raises reserved. All other outputs are then 0, apart from out_valid.
- R11: Outputs register the decode of the word sampled on the previous rising clock edge when in_valid was 1. When in_valid was 0, or during reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| rs_value | input | 32 | Value of the first source register |
| out_valid | output | 1 | Decoded fields valid |
| alu_sel | output | 4 | ALU function select |
| is_unsigned | output | 1 | Unsigned arithmetic |
| sign_result | output | 1 | Result is the sign of a subtraction |
| branch_kind | output | 2 | 00 none, 01 less-or-equal zero, 10 greater than zero |
| branch_taken | output | 1 | Branch condition holds |
| reserved | output | 1 | Word lies in a reserved encoding slot |

## Verification
Reserved-slot detection and branch-condition evaluation can both act on the same word. A zero-compare branch with a nonzero field in bits 20:16 is a branch opcode and a reserved encoding at once. The bench provokes this case with rs_value patterns that would make either branch taken. It judges the result against its own reference on the following clock, which requires reserved set, kind 00 and not taken. The bench also sweeps the full opcode and function-code space, and applies the boundary source values 0, 1, -1, the most negative value and the most positive value.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

    localparam int OPW  = 6;
    localparam int REGW = 5;

    typedef enum logic [3:0] {
        ALU_SLL = 4'd0,
        ALU_SRL = 4'd1,
        ALU_SRA = 4'd2,
        ALU_ADD = 4'd3,
        ALU_SUB = 4'd4,
        ALU_AND = 4'd5,
        ALU_OR  = 4'd6,
        ALU_XOR = 4'd7,
        ALU_NOR = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_LEZ  = 2'b01,
        BR_GTZ  = 2'b10
    } br_kind_e;

    typedef struct packed {
        alu_op_e  alu;
        logic     uns;
        logic     sign_res;
        br_kind_e kind;
        logic     rsvd;
    } dec_t;

    localparam logic [OPW-1:0] MAJ_REGREG = 6'b000000;
    localparam logic [OPW-1:0] MAJ_BLEZ   = 6'b000110;
    localparam logic [OPW-1:0] MAJ_BGTZ   = 6'b000111;

endpackage

// File: rtl/rdec_op_decode.sv
module rdec_op_decode
    import rdec_pkg::*;
(
    input  logic [OPW-1:0]  major,
    input  logic [OPW-1:0]  funct,
    input  logic [REGW-1:0] rt_field,
    output dec_t            dec
);

    localparam dec_t NOP_DEC  = '{alu: ALU_SLL, uns: 1'b0, sign_res: 1'b0,
                                  kind: BR_NONE, rsvd: 1'b0};
    localparam dec_t RSVD_DEC = '{alu: ALU_SLL, uns: 1'b0, sign_res: 1'b0,
                                  kind: BR_NONE, rsvd: 1'b1};

    dec_t rr_dec;
    dec_t imm_dec;

    // Register-register class: groups are aligned cubes of the function space.
    always_comb begin
        rr_dec = NOP_DEC;
        unique casez (funct)
            6'b0000??: begin
                unique case (funct[1:0])
                    2'b00:   rr_dec.alu = ALU_SLL;
                    2'b10:   rr_dec.alu = ALU_SRL;
                    2'b11:   rr_dec.alu = ALU_SRA;
                    default: rr_dec = RSVD_DEC;
                endcase
            end
            6'b1000??: begin
                rr_dec.alu = funct[1] ? ALU_SUB : ALU_ADD;
                rr_dec.uns = funct[0];
            end
            6'b1001??: begin
                unique case (funct[1:0])
                    2'b00:   rr_dec.alu = ALU_AND;
                    2'b01:   rr_dec.alu = ALU_OR;
                    2'b10:   rr_dec.alu = ALU_XOR;
                    default: rr_dec.alu = ALU_NOR;
                endcase
            end
            6'b10101?: begin
                rr_dec.alu      = ALU_SUB;
                rr_dec.sign_res = 1'b1;
                rr_dec.uns      = funct[0];
            end
            default: rr_dec = RSVD_DEC;
        endcase
    end

    // Immediate class: major opcodes 001xxx.
    always_comb begin
        imm_dec = NOP_DEC;
        unique case (major[2:0])
            3'b000: imm_dec.alu = ALU_ADD;
            3'b001: begin imm_dec.alu = ALU_ADD; imm_dec.uns = 1'b1; end
            3'b010: begin imm_dec.alu = ALU_SUB; imm_dec.sign_res = 1'b1; end
            3'b011: begin
                imm_dec.alu      = ALU_SUB;
                imm_dec.sign_res = 1'b1;
                imm_dec.uns      = 1'b1;
            end
            3'b100: imm_dec.alu = ALU_AND;
            3'b101: imm_dec.alu = ALU_OR;
            3'b110: imm_dec.alu = ALU_XOR;
            default: imm_dec = RSVD_DEC;
        endcase
    end

    always_comb begin
        dec = RSVD_DEC;
        unique casez (major)
            MAJ_REGREG: dec = rr_dec;
            MAJ_BLEZ, MAJ_BGTZ: begin
                if (rt_field == '0) begin
                    dec      = NOP_DEC;
                    dec.kind = major[0] ? BR_GTZ : BR_LEZ;
                end
            end
            6'b001???: dec = imm_dec;
            default:   dec = RSVD_DEC;
        endcase
    end

endmodule

// File: rtl/rdec_zero_branch.sv
module rdec_zero_branch
    import rdec_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] cmp_operand,
    input  br_kind_e      kind,
    output logic          taken
);

    logic equal;
    logic negative;

    assign equal    = (src == cmp_operand);
    assign negative = src[DW-1];

    always_comb begin
        unique case (kind)
            BR_LEZ:  taken = equal | negative;
            BR_GTZ:  taken = ~equal & ~negative;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/rdec_top.sv
module rdec_top
    import rdec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs_value,
    output logic            out_valid,
    output logic [3:0]      alu_sel,
    output logic            is_unsigned,
    output logic            sign_result,
    output logic [1:0]      branch_kind,
    output logic            branch_taken,
    output logic            reserved
);

    localparam int MAJ_LSB = XLEN - OPW;
    localparam int RT_LSB  = 16;
    localparam int RS_LSB  = RT_LSB + REGW;
    localparam logic [XLEN-1:0] RT_ZERO = '0;

    dec_t dec;
    logic taken;
    logic unused_fields;

    assign unused_fields = ^{instr[MAJ_LSB-1:RS_LSB], instr[RT_LSB-1:OPW]};

    rdec_op_decode u_dec (
        .major    (instr[XLEN-1:MAJ_LSB]),
        .funct    (instr[OPW-1:0]),
        .rt_field (instr[RT_LSB+REGW-1:RT_LSB]),
        .dec      (dec)
    );

    // Second comparator input is the zero register for both branch kinds.
    rdec_zero_branch #(.DW(XLEN)) u_br (
        .src         (rs_value),
        .cmp_operand (RT_ZERO),
        .kind        (dec.kind),
        .taken       (taken)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            alu_sel      <= 4'd0;
            is_unsigned  <= 1'b0;
            sign_result  <= 1'b0;
            branch_kind  <= 2'b00;
            branch_taken <= 1'b0;
            reserved     <= 1'b0;
        end else if (in_valid) begin
            out_valid    <= 1'b1;
            alu_sel      <= dec.alu;
            is_unsigned  <= dec.uns;
            sign_result  <= dec.sign_res;
            branch_kind  <= dec.kind;
            branch_taken <= taken;
            reserved     <= dec.rsvd;
        end else begin
            out_valid    <= 1'b0;
            alu_sel      <= 4'd0;
            is_unsigned  <= 1'b0;
            sign_result  <= 1'b0;
            branch_kind  <= 2'b00;
            branch_taken <= 1'b0;
            reserved     <= 1'b0;
        end
    end

    p_zero_word_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr == '0) |=> (out_valid && alu_sel == 4'd0 && !reserved
            && !is_unsigned && !sign_result && branch_kind == 2'b00 && !branch_taken));

    p_slt_is_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sign_result |-> (alu_sel == ALU_SUB));

    p_kind_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(branch_kind));

    p_taken_needs_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> (branch_kind != 2'b00));

    p_reserved_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reserved |-> (alu_sel == 4'd0 && !is_unsigned && !sign_result
            && branch_kind == 2'b00 && !branch_taken));

    p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !reserved && alu_sel == 4'd0));

endmodule

// File: tb/sim_rdec_top.sv
module sim_rdec_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_value = '0;
    logic        out_valid;
    logic [3:0]  alu_sel;
    logic        is_unsigned;
    logic        sign_result;
    logic [1:0]  branch_kind;
    logic        branch_taken;
    logic        reserved;

    int total = 0;
    int bad = 0;

    logic [10:0] exp_q;
    string       tag_q;
    bit          have_q = 0;

    always #10 clk = ~clk;

    rdec_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs_value(rs_value), .out_valid(out_valid), .alu_sel(alu_sel),
        .is_unsigned(is_unsigned), .sign_result(sign_result),
        .branch_kind(branch_kind), .branch_taken(branch_taken),
        .reserved(reserved)
    );

    function automatic logic [10:0] ref_out(bit v, logic [31:0] w, logic [31:0] rs);
        int alu = 0;
        bit u = 0, s = 0, res = 0, tk = 0;
        logic [1:0] kind = 2'b00;
        if (!v) return '0;
        case (w[31:26])
            0: case (w[5:0])
                0: alu = 0;
                2: alu = 1;
                3: alu = 2;
                32: alu = 3;
                33: begin alu = 3; u = 1; end
                34: alu = 4;
                35: begin alu = 4; u = 1; end
                36: alu = 5;
                37: alu = 6;
                38: alu = 7;
                39: alu = 8;
                42: begin alu = 4; s = 1; end
                43: begin alu = 4; s = 1; u = 1; end
                default: res = 1;
            endcase
            6, 7: begin
                if (w[20:16] != 0) res = 1;
                else if (w[31:26] == 6) begin
                    kind = 2'b01; tk = ($signed(rs) <= 0);
                end else begin
                    kind = 2'b10; tk = ($signed(rs) > 0);
                end
            end
            8: alu = 3;
            9: begin alu = 3; u = 1; end
            10: begin alu = 4; s = 1; end
            11: begin alu = 4; s = 1; u = 1; end
            12: alu = 5;
            13: alu = 6;
            14: alu = 7;
            default: res = 1;
        endcase
        return {1'b1, alu[3:0], u, s, kind, tk, res};
    endfunction

    function automatic string tag_of(bit v, logic [31:0] w);
        if (!v) return "R11";
        if (w == 0) return "R1";
        case (w[31:26])
            0: case (w[5:0])
                42, 43: return "R3";
                33, 35: return "R4";
                0, 2, 3, 32, 34, 36, 37, 38, 39: return "R2";
                default: return "R10";
            endcase
            6: return (w[20:16] != 0) ? "R9" : "R6 R7";
            7: return (w[20:16] != 0) ? "R9" : "R6 R8";
            8, 9, 10, 11, 12, 13, 14: return "R5";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [10:0] actual();
        return {out_valid, alu_sel, is_unsigned, sign_result, branch_kind,
                branch_taken, reserved};
    endfunction

    task automatic compare(string tag, logic [10:0] exp);
        total++;
        if (actual() !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, actual(), exp);
        end
    endtask

    // Drive at the falling edge; the value applied one cycle earlier is judged first.
    task automatic step(bit v, logic [31:0] w, logic [31:0] rs);
        @(negedge clk);
        if (have_q) compare(tag_q, exp_q);
        in_valid = v;
        instr    = w;
        rs_value = rs;
        exp_q    = ref_out(v, w, rs);
        tag_q    = tag_of(v, w);
        have_q   = 1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] edges [5];
        edges[0] = 32'h0000_0000;
        edges[1] = 32'h0000_0001;
        edges[2] = 32'hFFFF_FFFF;
        edges[3] = 32'h8000_0000;
        edges[4] = 32'h7FFF_FFFF;

        repeat (2) @(negedge clk);
        compare("R11", '0);                       // reset state
        rst_n = 1'b1;

        step(1, 32'h0, 32'h1234_5678);            // R1: all-zero word
        step(0, 32'hFFFF_FFFF, 32'h0);            // R11: idle cycle with garbage

        for (int f = 0; f < 64; f++)              // R2 R3 R4 R10: function space
            step(1, {6'd0, 20'($urandom), f[5:0]}, $urandom);

        for (int m = 0; m < 64; m++)              // R5 R6 R10: major space
            step(1, {m[5:0], 5'($urandom), 5'd0, 16'($urandom)}, $urandom);

        for (int k = 6; k <= 7; k++) begin        // R7 R8: boundary and random sources
            for (int e = 0; e < 5; e++)
                step(1, {k[5:0], 5'($urandom), 5'd0, 16'($urandom)}, edges[e]);
            for (int r = 0; r < 10; r++)
                step(1, {k[5:0], 5'($urandom), 5'd0, 16'($urandom)}, $urandom);
        end

        for (int k = 6; k <= 7; k++)              // R9: reserved and branch in one word
            for (int e = 0; e < 5; e++)
                step(1, {k[5:0], 5'($urandom), 5'(e + 1), 16'($urandom)}, edges[e]);

        for (int r = 0; r < 120; r++)             // mixed back-to-back traffic
            step(($urandom % 5) != 0, $urandom, $urandom);

        step(1, 32'h0, 32'h0);                    // R1 again after traffic
        step(0, 32'h0, 32'h0);
        @(negedge clk);
        compare(tag_q, exp_q);
        finish_run();
    end

endmodule